// File: doc/BRIEF.md
# Gated Bit-Serial Receive FIFO

This block buffers a demodulated serial bit stream, one bit per entry, until a host drains it. Each bit strobe from the receive path offers one bit. The buffer only starts to accept bits once a start condition has been seen, so that noise received before real traffic never takes up space. The start condition is chosen by configuration: the valid-data flag, a pulse from the sync-word match, or either of the two. After the start condition, filling stays enabled until the host asks for a restart. A restart also empties the buffer.

The host drains the buffer through a direct serial port. While its select line is held low, the head bit is shown on the data output. Each falling edge of the host serial clock removes that bit, and the following bit is then shown. A level interrupt compares the number of stored bits with a threshold given in bits. With the threshold at 1, the host can poll the interrupt line and stop reading when it drops. A small status word reports the buffer state and a sticky overflow flag. All logic runs on the reference clock. The host clock and select are synchronized to it.

Top module: `rx_bit_fifo`

## Requirements
- R1: After reset the buffer is empty and disarmed. `status_o` reads 5'b00010, `level_irq_o` is 0 when the threshold is 1 or more, and `host_sdo_o` is 0.
- R2: `trig_mode_i` selects the start condition: 2'b00 is `rx_valid_i` only, 2'b01 is `sync_hit_i` only, and 2'b10 or 2'b11 is either one. Strobed bits are dropped while the buffer is disarmed and no start condition is present. A strobe in the same cycle as the start condition is stored.
- R3: Once armed, the buffer stays armed when the start condition goes away. A `restart_i` pulse empties the buffer, disarms it and clears the overflow flag. A strobe in the restart cycle is dropped.
- R4: Bits leave in arrival order, oldest first. While the synchronized `host_sel_ni` is low, `host_sdo_o` shows the oldest stored bit. Each falling edge of `host_sck_i` removes that bit. The next bit is on `host_sdo_o` no later than the third rising reference edge after the falling edge is first sampled.
- R5: A falling host clock edge while the buffer is empty returns 0 on `host_sdo_o` and leaves the count at 0.
- R6: A strobe into a full buffer with no removal in the same cycle discards the new bit and sets the sticky overflow flag, `status_o[4]`. A `status_rd_i` pulse clears the flag. A new overflow in the same cycle as the clear keeps the flag set.
- R7: When a strobe and a removal fall in the same cycle and the buffer is not empty, both complete and the count does not change.
- R8: `level_irq_o` is high exactly when the stored bit count is greater than or equal to `level_thresh_i`.
- R9: The status bits are: `status_o[0]` armed, `[1]` empty, `[2]` full (DEPTH bits stored), `[3]` level interrupt condition, `[4]` overflow.
- R10: While the synchronized `host_sel_ni` is high, `host_sdo_o` is 0 and host clock edges remove nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rx_bit_i | input | 1 | Recovered data bit |
| rx_strobe_i | input | 1 | One-cycle strobe offering `rx_bit_i` |
| rx_valid_i | input | 1 | Valid-data flag from the receive path |
| sync_hit_i | input | 1 | Sync-word match pulse |
| trig_mode_i | input | 2 | Start-condition select |
| level_thresh_i | input | 7 | Interrupt threshold in bits (0 to DEPTH) |
| restart_i | input | 1 | Flush, disarm and clear overflow |
| status_rd_i | input | 1 | Status read pulse; clears overflow |
| host_sel_ni | input | 1 | Host buffer select, active low |
| host_sck_i | input | 1 | Host serial clock |
| host_sdo_o | output | 1 | Host serial data out |
| level_irq_o | output | 1 | Fill-level interrupt |
| status_o | output | 5 | Status word |

## Verification
The assertions rely on three things about the host port. First, the host clock and select change slowly compared with the reference clock, so that a falling edge is seen as a single-cycle event. Second, each host clock phase lasts at least four reference cycles, so that a removal has settled before the host samples again. Third, the bit strobe is a single-cycle pulse. The bench drives every host clock phase for exactly four reference cycles and changes select only while the clock is low and idle. It also drives all receive inputs one time unit after a rising edge, so no input moves near the sampling edge.

// File: rtl/rx_bit_fifo_pkg.sv
package rx_bit_fifo_pkg;

  typedef enum logic [1:0] {
    TRIG_VALID  = 2'b00,
    TRIG_SYNC   = 2'b01,
    TRIG_EITHER = 2'b10,
    TRIG_ANY    = 2'b11
  } trig_mode_e;

  typedef struct packed {
    logic ovf;
    logic level;
    logic full;
    logic empty;
    logic armed;
  } fifo_status_t;

endpackage

// File: rtl/rx_rst_sync.sv
module rx_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);

  logic stage_q;
  logic out_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign rst_sync_no = out_q;

endmodule

// File: rtl/rx_host_sync.sv
module rx_host_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sck_i,
  input  logic sel_ni,
  output logic sel_active_o,
  output logic pop_o
);

  logic [SYNC_STAGES-1:0] sck_q;
  logic [SYNC_STAGES-1:0] sel_q;
  logic                   sck_prev_q;
  logic [SYNC_STAGES-1:0] sck_d;
  logic [SYNC_STAGES-1:0] sel_d;

  // Shift chains for both host lines
  always_comb begin
    sck_d = {sck_q[SYNC_STAGES-2:0], sck_i};
    sel_d = {sel_q[SYNC_STAGES-2:0], sel_ni};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q      <= '0;
      sel_q      <= '1;
      sck_prev_q <= 1'b0;
    end else begin
      sck_q      <= sck_d;
      sel_q      <= sel_d;
      sck_prev_q <= sck_q[SYNC_STAGES-1];
    end
  end

  assign sel_active_o = ~sel_q[SYNC_STAGES-1];
  assign pop_o        = sck_prev_q & ~sck_q[SYNC_STAGES-1] & sel_active_o;

  // R4: a detected host clock fall is a single-cycle event
  a_r4_pop_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_o |=> !pop_o);

endmodule

// File: rtl/rx_fill_gate.sv
module rx_fill_gate
  import rx_bit_fifo_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] trig_mode_i,
  input  logic       valid_i,
  input  logic       sync_i,
  input  logic       strobe_i,
  input  logic       restart_i,
  output logic       armed_o,
  output logic       push_o
);

  logic armed_q;
  logic armed_d;
  logic trig_now;

  always_comb begin
    unique case (trig_mode_e'(trig_mode_i))
      TRIG_VALID: trig_now = valid_i;
      TRIG_SYNC:  trig_now = sync_i;
      default:    trig_now = valid_i | sync_i;
    endcase
  end

  always_comb begin
    armed_d = armed_q;
    if (restart_i) begin
      armed_d = 1'b0;
    end else if (trig_now) begin
      armed_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
    end else begin
      armed_q <= armed_d;
    end
  end

  assign armed_o = armed_q;
  assign push_o  = strobe_i & (armed_q | trig_now) & ~restart_i;

  // R3: restart always leaves the gate disarmed
  a_r3_restart_disarms: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> !armed_o);

  // R3: arming persists without restart
  a_r3_arm_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_o && !restart_i) |=> armed_o);

endmodule

// File: rtl/rx_bit_store.sv
module rx_bit_store #(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             push_i,
  input  logic             bit_i,
  input  logic             pop_i,
  output logic             head_o,
  output logic [CNT_W-1:0] count_o,
  output logic             full_o,
  output logic             empty_o,
  output logic             ovf_o
);

  localparam logic [PTR_W-1:0] LAST_PTR  = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] DEPTH_CNT = CNT_W'(DEPTH);

  logic [DEPTH-1:0] mem_q;
  logic [PTR_W-1:0] wr_ptr_q, wr_ptr_d;
  logic [PTR_W-1:0] rd_ptr_q, rd_ptr_d;
  logic [CNT_W-1:0] count_q, count_d;
  logic             pop_ok;
  logic             push_ok;

  assign empty_o = (count_q == '0);
  assign full_o  = (count_q == DEPTH_CNT);
  assign pop_ok  = pop_i & ~empty_o & ~flush_i;
  assign push_ok = push_i & (~full_o | pop_ok) & ~flush_i;
  assign ovf_o   = push_i & full_o & ~pop_ok & ~flush_i;

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    count_d  = count_q;
    if (flush_i) begin
      wr_ptr_d = '0;
      rd_ptr_d = '0;
      count_d  = '0;
    end else begin
      if (push_ok) begin
        wr_ptr_d = (wr_ptr_q == LAST_PTR) ? '0 : wr_ptr_q + 1'b1;
      end
      if (pop_ok) begin
        rd_ptr_d = (rd_ptr_q == LAST_PTR) ? '0 : rd_ptr_q + 1'b1;
      end
      if (push_ok && !pop_ok) begin
        count_d = count_q + 1'b1;
      end else if (pop_ok && !push_ok) begin
        count_d = count_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      count_q  <= count_d;
    end
  end

  // Storage bits carry no reset; the head is masked while empty
  always_ff @(posedge clk_i) begin
    if (push_ok) begin
      mem_q[wr_ptr_q] <= bit_i;
    end
  end

  assign head_o  = mem_q[rd_ptr_q] & ~empty_o;
  assign count_o = count_q;

  a_r6_count_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= DEPTH_CNT);

  a_r7_push_pop_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && pop_i && !empty_o && !flush_i) |=> $stable(count_o));

  a_r5_empty_pop_noop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && empty_o && !push_i) |=> (count_o == '0));

  a_r2_no_push_no_growth: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !push_i |=> (count_o <= $past(count_o)));

endmodule

// File: rtl/rx_bit_fifo.sv
module rx_bit_fifo
  import rx_bit_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rx_bit_i,
  input  logic             rx_strobe_i,
  input  logic             rx_valid_i,
  input  logic             sync_hit_i,
  input  logic [1:0]       trig_mode_i,
  input  logic [CNT_W-1:0] level_thresh_i,
  input  logic             restart_i,
  input  logic             status_rd_i,
  input  logic             host_sel_ni,
  input  logic             host_sck_i,
  output logic             host_sdo_o,
  output logic             level_irq_o,
  output logic [4:0]       status_o
);

  logic             rst_n;
  logic             sel_active;
  logic             host_pop;
  logic             armed;
  logic             push;
  logic             head;
  logic [CNT_W-1:0] count;
  logic             full;
  logic             empty;
  logic             ovf_evt;
  logic             ovf_q, ovf_d;
  fifo_status_t     status;

  rx_rst_sync u_rst_sync (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_n)
  );

  rx_host_sync #(.SYNC_STAGES(2)) u_host_sync (
    .clk_i        (clk_i),
    .rst_ni       (rst_n),
    .sck_i        (host_sck_i),
    .sel_ni       (host_sel_ni),
    .sel_active_o (sel_active),
    .pop_o        (host_pop)
  );

  rx_fill_gate u_gate (
    .clk_i       (clk_i),
    .rst_ni      (rst_n),
    .trig_mode_i (trig_mode_i),
    .valid_i     (rx_valid_i),
    .sync_i      (sync_hit_i),
    .strobe_i    (rx_strobe_i),
    .restart_i   (restart_i),
    .armed_o     (armed),
    .push_o      (push)
  );

  rx_bit_store #(.DEPTH(DEPTH)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .flush_i (restart_i),
    .push_i  (push),
    .bit_i   (rx_bit_i),
    .pop_i   (host_pop),
    .head_o  (head),
    .count_o (count),
    .full_o  (full),
    .empty_o (empty),
    .ovf_o   (ovf_evt)
  );

  // Sticky overflow: a new event wins over a clear in the same cycle
  always_comb begin
    ovf_d = ovf_q;
    if (restart_i) begin
      ovf_d = 1'b0;
    end else if (ovf_evt) begin
      ovf_d = 1'b1;
    end else if (status_rd_i) begin
      ovf_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q <= 1'b0;
    end else begin
      ovf_q <= ovf_d;
    end
  end

  assign level_irq_o = (count >= level_thresh_i);
  assign host_sdo_o  = head & sel_active;

  always_comb begin
    status.ovf   = ovf_q;
    status.level = level_irq_o;
    status.full  = full;
    status.empty = empty;
    status.armed = armed;
  end
  assign status_o = status;

  a_r6_overflow_sets: assert property (@(posedge clk_i) disable iff (!rst_n)
    (ovf_evt && !restart_i) |=> status_o[4]);

  a_r3_restart_empties: assert property (@(posedge clk_i) disable iff (!rst_n)
    restart_i |=> (status_o[1] && !status_o[4]));

  a_r10_idle_sdo_low: assert property (@(posedge clk_i) disable iff (!rst_n)
    !sel_active |-> !host_sdo_o);

endmodule

// File: tb/tb_rx_bit_fifo.sv
module tb_rx_bit_fifo;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 64;
  localparam int CW         = $clog2(DEPTH + 1);

  logic          clk = 1'b0;
  logic          rst_n;
  logic          rx_bit, rx_strobe, rx_valid, sync_hit;
  logic [1:0]    trig_mode;
  logic [CW-1:0] thresh;
  logic          restart, status_rd, sel_n, sck;
  logic          sdo, irq;
  logic [4:0]    status;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_bit_fifo #(.DEPTH(DEPTH)) dut (
    .clk_i(clk), .rst_ni(rst_n), .rx_bit_i(rx_bit), .rx_strobe_i(rx_strobe),
    .rx_valid_i(rx_valid), .sync_hit_i(sync_hit), .trig_mode_i(trig_mode),
    .level_thresh_i(thresh), .restart_i(restart), .status_rd_i(status_rd),
    .host_sel_ni(sel_n), .host_sck_i(sck), .host_sdo_o(sdo),
    .level_irq_o(irq), .status_o(status)
  );

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Count inferred at the ports through the threshold compare (R8)
  task automatic check_count(input int exp, input string req);
    logic [CW-1:0] saved;
    saved  = thresh;
    thresh = CW'(exp);
    #1;
    check(irq == 1'b1, req, irq, 1);
    thresh = CW'(exp + 1);
    #1;
    check(irq == 1'b0, req, irq, 0);
    thresh = saved;
    #1;
  endtask

  task automatic push(input bit b);
    rx_bit    = b;
    rx_strobe = 1'b1;
    tick();
    rx_strobe = 1'b0;
  endtask

  task automatic do_restart();
    restart = 1'b1;
    tick();
    restart = 1'b0;
  endtask

  task automatic select(input bit on);
    sel_n = ~on;
    tick(3);
  endtask

  // One host bit: sample head, high phase, low phase (pop on the fall)
  task automatic host_bit(output bit b);
    b   = sdo;
    sck = 1'b1;
    tick(4);
    sck = 1'b0;
    tick(4);
  endtask

  task automatic t_reset();
    thresh = 7'd1;
    #1;
    check(status == 5'b00010, "R1 status", status, 2);
    check(status[1] == 1'b1, "R9 empty bit", status[1], 1);
    check(irq == 1'b0, "R1 irq", irq, 0);
    check(sdo == 1'b0, "R1 sdo", sdo, 0);
  endtask

  task automatic t_gate_valid();
    trig_mode = 2'b00;
    push(1'b1);
    sync_hit = 1'b1;
    push(1'b1);
    sync_hit = 1'b0;
    check_count(0, "R2 mode00 drops and ignores sync");
    check(status[0] == 1'b0, "R2 still disarmed", status[0], 0);
    rx_valid = 1'b1;
    push(1'b1);
    rx_valid = 1'b0;
    check_count(1, "R2 trigger-cycle strobe stored");
    check(status[0] == 1'b1, "R9 armed bit", status[0], 1);
    push(1'b0);
    push(1'b1);
    check_count(3, "R3 stays armed");
    do_restart();
    check_count(0, "R3 restart empties");
    check(status == 5'b00010, "R3 restart disarms", status, 2);
  endtask

  task automatic t_gate_sync();
    trig_mode = 2'b01;
    rx_valid  = 1'b1;
    push(1'b1);
    rx_valid  = 1'b0;
    check_count(0, "R2 mode01 ignores valid");
    sync_hit = 1'b1;
    tick();
    sync_hit = 1'b0;
    push(1'b1);
    check_count(1, "R2 sync arms");
    trig_mode = 2'b10;
    do_restart();
    rx_valid = 1'b1;
    push(1'b0);
    rx_valid = 1'b0;
    check_count(1, "R2 mode10 valid arms");
    restart   = 1'b1;
    rx_strobe = 1'b1;
    tick();
    restart   = 1'b0;
    rx_strobe = 1'b0;
    check_count(0, "R3 strobe in restart dropped");
  endtask

  task automatic t_order();
    bit pat [8] = '{1, 0, 1, 1, 0, 0, 1, 0};
    bit b;
    trig_mode = 2'b11;
    sync_hit  = 1'b1;
    tick();
    sync_hit  = 1'b0;
    foreach (pat[i]) push(pat[i]);
    check_count(8, "R8 count 8");
    check(status[3] == 1'b1, "R9 level bit", status[3], 1);
    sck = 1'b1; tick(4); sck = 1'b0; tick(4);
    check_count(8, "R10 deselected clock ignored");
    check(sdo == 1'b0, "R10 deselected sdo low", sdo, 0);
    select(1'b1);
    for (int i = 0; i < 8; i++) begin
      check(irq == 1'b1, "R8 poll high while bits remain", irq, 1);
      host_bit(b);
      check(b == pat[i], "R4 order", b, pat[i]);
    end
    check(irq == 1'b0, "R8 poll low when empty", irq, 0);
    host_bit(b);
    check(b == 1'b0, "R5 empty read returns 0", b, 0);
    check_count(0, "R5 count unchanged");
    select(1'b0);
  endtask

  task automatic t_push_pop();
    bit exp [5] = '{0, 1, 1, 0, 1};
    bit b;
    push(1'b1);
    push(1'b0);
    select(1'b1);
    b   = sdo;
    sck = 1'b1;
    tick(4);
    sck = 1'b0;
    push(1'b1); push(1'b1); push(1'b0); push(1'b1);
    check(b == 1'b1, "R7 first head", b, 1);
    check_count(5, "R7 push and pop both complete");
    for (int i = 0; i < 5; i++) begin
      host_bit(b);
      check(b == exp[i], "R7 order after overlap", b, exp[i]);
    end
    select(1'b0);
  endtask

  task automatic t_overflow();
    bit b;
    bit ok = 1'b1;
    for (int i = 0; i < DEPTH; i++) push(bit'(i % 3 == 0));
    check(status[2] == 1'b1, "R9 full bit", status[2], 1);
    check(status[4] == 1'b0, "R6 no overflow yet", status[4], 0);
    push(1'b1);
    check(status[4] == 1'b1, "R6 overflow set", status[4], 1);
    check_count(DEPTH, "R6 count stays full");
    status_rd = 1'b1;
    tick();
    status_rd = 1'b0;
    check(status[4] == 1'b0, "R6 read clears", status[4], 0);
    status_rd = 1'b1;
    push(1'b1);
    status_rd = 1'b0;
    check(status[4] == 1'b1, "R6 set wins over clear", status[4], 1);
    select(1'b1);
    for (int i = 0; i < DEPTH; i++) begin
      host_bit(b);
      if (b != bit'(i % 3 == 0)) ok = 1'b0;
    end
    check(ok, "R6 stored bits intact, extras discarded", ok, 1);
    check_count(0, "R6 drained");
    select(1'b0);
    do_restart();
    check(status[4] == 1'b0, "R3 restart clears overflow", status[4], 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; rx_bit = 1'b0; rx_strobe = 1'b0; rx_valid = 1'b0;
    sync_hit = 1'b0; trig_mode = 2'b00; thresh = 7'd1; restart = 1'b0;
    status_rd = 1'b0; sel_n = 1'b1; sck = 1'b0;
    tick(3);
    rst_n = 1'b1;
    tick(3);
    t_reset();
    t_gate_valid();
    t_gate_sync();
    t_order();
    t_push_pop();
    t_overflow();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule